// File: doc/BRIEF.md
# Audio Underrun and Interrupt Status Unit

This unit watches the audio sample path that feeds a display link. Two events are of interest: the buffer engine signals that a buffer has been consumed, and the frame inserter asks for a sample at a point where the sample store is empty (an underrun). Each event latches a sticky flag in a status register. Software clears a flag by writing a one to its bit. Each flag has its own enable, and a single interrupt line combines the enabled flags.

When an underrun happens, the unit tells the packet side how to fill the gap. A configuration bit chooses between silence samples and null packets. A second configuration bit selects one of two link modes and is passed straight to an output. The insertion request is a single-cycle query that is answered combinationally in the same cycle. It carries no valid/ready handshake and applies no back-pressure: the inserter never waits, and the fill code tells it what to put in the slot.

Top module: `aud_irq_status_unit`

## Requirements
- R1: After reset the status and configuration registers read 0, `irq_o` is 0, `link_mode_o` is 0 and `fill_sel_o` is 2'b00.
- R2: Status bit 31 (underrun flag) sets on the clock edge at which `ins_req_i`=1 and `smp_avail_i`=0. A request made while a sample is available does not set it.
- R3: Status bit 29 (buffer-done flag) sets on the clock edge at which `buf_done_i`=1.
- R4: A write to address 0 clears each of bits 31 and 29 whose data bit is 1. A data bit of 0 leaves that flag unchanged.
- R5: If a set event and a clearing write hit the same flag in the same cycle, the flag is 1 afterwards.
- R6: Status bit 15 (underrun interrupt enable) and bit 14 (buffer-done interrupt enable) are read/write through address 0. All other status bits read 0.
- R7: `irq_o` = (bit31 AND bit15) OR (bit29 AND bit14), taken from the current register contents.
- R8: `fill_sel_o` is combinational. It is 2'b01 (silence) when `ins_req_i`=1, `smp_avail_i`=0 and config bit 1 is 1. It is 2'b10 (null packet) in the same condition with config bit 1 = 0. In every other case it is 2'b00 (normal data).
- R9: Address 1 holds the configuration. Bit 0 is the link mode and drives `link_mode_o`; bit 1 is the silence-fill select. Other bits read 0. Other addresses read 0, and writes to them change nothing.
- R10: `reg_rdata_o` is a pure function of `reg_addr_i` and register state. Reading has no side effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address (0 status, 1 config) |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` |
| buf_done_i | input | 1 | Buffer-done event pulse |
| ins_req_i | input | 1 | Sample needed at a frame insertion point |
| smp_avail_i | input | 1 | Sample store holds at least one sample |
| fill_sel_o | output | 2 | Slot fill: 00 data, 01 silence, 10 null packet |
| link_mode_o | output | 1 | Link mode select from config bit 0 |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench sweeps all sixteen combinations of the two flags and their two enables. A design that crossed an enable with the wrong flag, or that ignored one enable, would raise or miss the interrupt on some of them. It also writes every pattern of the two clear bits. A design that cleared on a zero, or cleared both flags from one bit, would lose a flag. It drives an event and a clearing write into the same cycle, where a design with the wrong priority would drop the event. It walks the fill output over every combination of request, availability and policy, and here a registered or inverted fill code would show the wrong slot type.

// File: rtl/aud_stat_pkg.sv
package aud_stat_pkg;
  localparam int REG_W          = 32;
  localparam int ST_URUN_BIT    = 31;
  localparam int ST_DONE_BIT    = 29;
  localparam int ST_URUN_EN_BIT = 15;
  localparam int ST_DONE_EN_BIT = 14;
  localparam int CF_LINK_BIT    = 0;
  localparam int CF_SIL_BIT     = 1;
  localparam int NUM_FLAGS      = 2;
  localparam int FLAG_URUN      = 0;
  localparam int FLAG_DONE      = 1;

  typedef enum logic [1:0] {
    FILL_DATA    = 2'b00,
    FILL_SILENCE = 2'b01,
    FILL_NULL    = 2'b10
  } fill_e;
endpackage

// File: rtl/aud_w1c_flag.sv
module aud_w1c_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/aud_status_regs.sv
module aud_status_regs
  import aud_stat_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         urun_evt_i,
  input  logic         done_evt_i,
  output logic [W-1:0] status_o,
  output logic         urun_o,
  output logic         done_o,
  output logic         urun_en_o,
  output logic         done_en_o
);
  logic [NUM_FLAGS-1:0] evt_v;
  logic [NUM_FLAGS-1:0] q_v;

  assign evt_v[FLAG_URUN] = urun_evt_i;
  assign evt_v[FLAG_DONE] = done_evt_i;

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    localparam int POS = (g == FLAG_URUN) ? ST_URUN_BIT : ST_DONE_BIT;
    aud_w1c_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (evt_v[g]),
      .clr_i (wr_i & wdata_i[POS]),
      .q_o   (q_v[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      urun_en_o <= 1'b0;
      done_en_o <= 1'b0;
    end else if (wr_i) begin
      urun_en_o <= wdata_i[ST_URUN_EN_BIT];
      done_en_o <= wdata_i[ST_DONE_EN_BIT];
    end
  end

  assign urun_o = q_v[FLAG_URUN];
  assign done_o = q_v[FLAG_DONE];

  always_comb begin
    status_o                 = '0;
    status_o[ST_URUN_BIT]    = urun_o;
    status_o[ST_DONE_BIT]    = done_o;
    status_o[ST_URUN_EN_BIT] = urun_en_o;
    status_o[ST_DONE_EN_BIT] = done_en_o;
  end
endmodule

// File: rtl/aud_cfg_reg.sv
module aud_cfg_reg
  import aud_stat_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cfg_o,
  output logic         link_mode_o,
  output logic         sil_fill_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_mode_o <= 1'b0;
      sil_fill_o  <= 1'b0;
    end else if (wr_i) begin
      link_mode_o <= wdata_i[CF_LINK_BIT];
      sil_fill_o  <= wdata_i[CF_SIL_BIT];
    end
  end

  always_comb begin
    cfg_o              = '0;
    cfg_o[CF_LINK_BIT] = link_mode_o;
    cfg_o[CF_SIL_BIT]  = sil_fill_o;
  end
endmodule

// File: rtl/aud_fill_ctrl.sv
module aud_fill_ctrl
  import aud_stat_pkg::*;
(
  input  logic       ins_req_i,
  input  logic       smp_avail_i,
  input  logic       sil_fill_i,
  output logic       starve_o,
  output logic [1:0] fill_o
);
  fill_e fill;

  assign starve_o = ins_req_i & ~smp_avail_i;

  always_comb begin
    fill = FILL_DATA;
    if (starve_o) fill = sil_fill_i ? FILL_SILENCE : FILL_NULL;
  end

  assign fill_o = fill;
endmodule

// File: rtl/aud_irq_status_unit.sv
module aud_irq_status_unit
  import aud_stat_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              buf_done_i,
  input  logic              ins_req_i,
  input  logic              smp_avail_i,
  output logic [1:0]        fill_sel_o,
  output logic              link_mode_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CFG    = ADDR_W'(1);

  logic [REG_W-1:0] status_w, cfg_w;
  logic urun_q, done_q, urun_en_q, done_en_q, sil_fill_q, starve;
  logic wr_status, wr_cfg;

  assign wr_status = reg_wr_i && (reg_addr_i == A_STATUS);
  assign wr_cfg    = reg_wr_i && (reg_addr_i == A_CFG);

  aud_fill_ctrl u_fill (
    .ins_req_i   (ins_req_i),
    .smp_avail_i (smp_avail_i),
    .sil_fill_i  (sil_fill_q),
    .starve_o    (starve),
    .fill_o      (fill_sel_o)
  );

  aud_status_regs #(.W(REG_W)) u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_i       (wr_status),
    .wdata_i    (reg_wdata_i),
    .urun_evt_i (starve),
    .done_evt_i (buf_done_i),
    .status_o   (status_w),
    .urun_o     (urun_q),
    .done_o     (done_q),
    .urun_en_o  (urun_en_q),
    .done_en_o  (done_en_q)
  );

  aud_cfg_reg #(.W(REG_W)) u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_i        (wr_cfg),
    .wdata_i     (reg_wdata_i),
    .cfg_o       (cfg_w),
    .link_mode_o (link_mode_o),
    .sil_fill_o  (sil_fill_q)
  );

  always_comb begin
    unique case (reg_addr_i)
      A_STATUS: reg_rdata_o = status_w;
      A_CFG:    reg_rdata_o = cfg_w;
      default:  reg_rdata_o = '0;
    endcase
  end

  assign irq_o = (urun_q & urun_en_q) | (done_q & done_en_q);
endmodule

// File: rtl/aud_irq_status_chk.sv
module aud_irq_status_chk #(
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [31:0]       reg_wdata_i,
  input logic              buf_done_i,
  input logic              ins_req_i,
  input logic              smp_avail_i,
  input logic [1:0]        fill_sel_o,
  input logic              irq_o,
  input logic              urun_q,
  input logic              done_q
);
  logic st_wr;
  assign st_wr = reg_wr_i && (reg_addr_i == '0);

  AST_URUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_req_i && !smp_avail_i) |=> urun_q); // R2
  AST_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    buf_done_i |=> done_q); // R3
  AST_URUN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && reg_wdata_i[31] && !(ins_req_i && !smp_avail_i)) |=> !urun_q); // R4
  AST_URUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (urun_q && !(st_wr && reg_wdata_i[31])) |=> urun_q); // R4
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !(st_wr && reg_wdata_i[29])) |=> done_q); // R4
  AST_IRQ_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (urun_q || done_q)); // R7
  AST_FILL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(ins_req_i && !smp_avail_i) |-> (fill_sel_o == 2'b00)); // R8
  AST_FILL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fill_sel_o)); // R8
endmodule

bind aud_irq_status_unit aud_irq_status_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .buf_done_i  (buf_done_i),
  .ins_req_i   (ins_req_i),
  .smp_avail_i (smp_avail_i),
  .fill_sel_o  (fill_sel_o),
  .irq_o       (irq_o),
  .urun_q      (urun_q),
  .done_q      (done_q)
);

// File: tb/tb_aud_irq_status_unit.sv
`timescale 1ns/1ps
module tb_aud_irq_status_unit;
  localparam int ADDR_W = 2;
  localparam real HALF = 2.0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic buf_done = 1'b0;
  logic ins_req = 1'b0;
  logic smp_avail = 1'b1;
  logic [1:0] fill_sel;
  logic link_mode;
  logic irq;

  int checks = 0;
  int failures = 0;
  bit done_run = 0;

  always #(HALF) clk = ~clk;

  aud_irq_status_unit #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .buf_done_i(buf_done),
    .ins_req_i(ins_req), .smp_avail_i(smp_avail), .fill_sel_o(fill_sel),
    .link_mode_o(link_mode), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic do_rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic pulse_urun();
    @(negedge clk); ins_req = 1'b1; smp_avail = 1'b0;
    @(negedge clk); ins_req = 1'b0; smp_avail = 1'b1;
  endtask

  task automatic pulse_done();
    @(negedge clk); buf_done = 1'b1;
    @(negedge clk); buf_done = 1'b0;
  endtask

  localparam logic [31:0] B_U  = 32'h8000_0000;
  localparam logic [31:0] B_D  = 32'h2000_0000;
  localparam logic [31:0] B_UE = 32'h0000_8000;
  localparam logic [31:0] B_DE = 32'h0000_4000;

  initial begin
    #(HALF * 2 * 150000);
    if (!done_run) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, rd2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    do_rd(0, rd); check("R1 status", rd, 32'h0);
    do_rd(1, rd); check("R1 config", rd, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 link", {31'b0, link_mode}, 32'h0);
    check("R1 fill", {30'b0, fill_sel}, 32'h0);

    // R2 request with sample available sets nothing
    @(negedge clk); ins_req = 1'b1; smp_avail = 1'b1;
    @(negedge clk); ins_req = 1'b0;
    do_rd(0, rd); check("R2 no underrun when sample present", rd, 32'h0);

    // R8 fill sweep over policy x request x availability
    for (int s = 0; s < 2; s++) begin
      do_wr(1, s << 1);
      for (int c = 0; c < 4; c++) begin
        logic [1:0] exp;
        @(negedge clk);
        ins_req = c[0]; smp_avail = c[1];
        #0.5;
        exp = (c[0] && !c[1]) ? ((s == 1) ? 2'b01 : 2'b10) : 2'b00;
        check("R8 fill", {30'b0, fill_sel}, {30'b0, exp});
        @(negedge clk); ins_req = 1'b0; smp_avail = 1'b1;
      end
    end

    // R9 config and link mode
    do_wr(1, 32'h0000_0001);
    check("R9 link mode", {31'b0, link_mode}, 32'h1);
    do_wr(1, 32'hFFFF_FFFF);
    do_rd(1, rd); check("R9 config unused bits", rd, 32'h3);
    do_wr(1, 32'h0);
    check("R9 link cleared", {31'b0, link_mode}, 32'h0);

    // R6 unused status bits, enables read back, flags cleared by W1C
    do_wr(0, 32'hFFFF_FFFF);
    do_rd(0, rd); check("R6 status read back", rd, B_UE | B_DE);
    do_wr(0, 32'h0);
    do_rd(0, rd); check("R6 enables cleared", rd, 32'h0);

    // R2 R3 R7 sweep over flags and enables
    for (int k = 0; k < 16; k++) begin
      logic [31:0] exp;
      do_wr(0, B_U | B_D | (k[2] ? B_UE : 0) | (k[3] ? B_DE : 0));
      if (k[0]) pulse_urun();
      if (k[1]) pulse_done();
      exp = (k[0] ? B_U : 0) | (k[1] ? B_D : 0) | (k[2] ? B_UE : 0) | (k[3] ? B_DE : 0);
      do_rd(0, rd); check("R2 R3 flag state", rd, exp);
      check("R7 irq", {31'b0, irq}, {31'b0, (k[0] & k[2]) | (k[1] & k[3])});
    end

    // R4 W1C pattern sweep
    for (int p = 0; p < 4; p++) begin
      pulse_urun(); pulse_done();
      do_wr(0, (p[0] ? B_U : 0) | (p[1] ? B_D : 0));
      do_rd(0, rd);
      check("R4 w1c", rd, (p[0] ? 0 : B_U) | (p[1] ? 0 : B_D));
      do_wr(0, B_U | B_D);
    end

    // R5 set beats clear in the same cycle
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 0; reg_wdata = B_U | B_D;
    ins_req = 1'b1; smp_avail = 1'b0; buf_done = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 0; ins_req = 1'b0; smp_avail = 1'b1; buf_done = 1'b0;
    do_rd(0, rd); check("R5 set wins", rd, B_U | B_D);

    // R10 repeated reads have no effect
    do_rd(0, rd);
    repeat (3) @(negedge clk);
    do_rd(0, rd2); check("R10 read no side effect", rd2, rd);

    // R9 unmapped address: reads 0, write ignored
    do_wr(2, 32'hFFFF_FFFF);
    do_rd(2, rd); check("R9 unmapped reads zero", rd, 32'h0);
    do_rd(0, rd); check("R9 unmapped write ignored status", rd, B_U | B_D);
    do_rd(1, rd); check("R9 unmapped write ignored config", rd, 32'h0);

    done_run = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule